// File: doc/BRIEF.md
# External Bus Cycle Sequencer for an 8-bit Harvard Controller

This block turns simple core requests into the multiplexed external memory bus of an 8-bit controller with separate code and data spaces. It runs on the oscillator clock. A machine cycle is 12 clocks: six states of two phases each. The block counts these clocks and, once per machine cycle, takes a request from the core. The request is a code fetch, an external data read, an external data write, or nothing, which gives an internal cycle. For every clock of the machine cycle it drives the address latch enable (ALE), the active-low code strobe, the read and write strobes, the shared low address/data byte with its output enable, and the high address byte.

Code and read bytes come back to the core as a one-clock response. The block also holds the two port latch registers that the bus borrows. The low port latch is forced to all ones by any external access. The high port latch is forced to all ones by a code fetch. Data accesses leave the high port latch alone: the pins show the address during a wide access, and the latch value appears again afterwards.

Top module: `xbus_seq`

## Requirements
- R1: Phase 0 of a machine cycle is the first clock after a request is sampled, and phase 11 is the last. `slot_ack` is high exactly during phase 11, and a request is sampled at the clock edge that ends that phase. Request kind encoding: 0 = internal, 1 = code fetch, 2 = data read, 3 = data write. A request with `req_valid` low is internal. While reset is held, and until the first edge after reset, the outputs are: `ale`=0, all strobes 1, `p0_oe`=0, `slot_ack`=1, and both port latches 8'hFF.
- R2: In internal and fetch cycles, `ale` is high in phases 0, 1, 6 and 7, which gives two pulses per machine cycle. In data cycles, `ale` is high only in phases 0 and 1.
- R3: In phases 0 and 1 of any external cycle, `p0_oe`=1 and `p0_out` carries the low address byte. In an internal cycle, `p0_oe` stays 0 for the whole cycle.
- R4: In a fetch cycle, `psen_n` is low in phases 3 to 5 only and `p0_oe` is 0 from phase 2. `p0_in` is captured at the edge that ends phase 5 and is returned on `rsp_data` with `rsp_valid` high during phase 6.
- R5: In a read cycle, `rd_n` is low in phases 5 to 10 and `p0_oe` is 0 from phase 2. `p0_in` is captured at the edge that ends phase 10 and is returned with `rsp_valid` high during phase 11.
- R6: In a write cycle, `wr_n` is low in phases 5 to 10, and `p0_out` drives the write byte with `p0_oe`=1 in phases 2 to 11.
- R7: `p2_out` carries the high address byte for all 12 phases of a fetch cycle and of a data cycle with `req_wide`=1. Otherwise it shows the high port latch.
- R8: The edge that takes an external request loads 8'hFF into the low port latch. The edge that takes a fetch also loads 8'hFF into the high port latch. These loads override a core port write on the same edge. Data accesses never change the high port latch. A core port write on any other edge loads `port_wdata`.
- R9: At most one of `psen_n`, `rd_n` and `wr_n` is low at any time, and none of them is low while `ale` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Oscillator clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Request present in the sampling slot |
| req_kind | input | 2 | 0 internal, 1 fetch, 2 read, 3 write |
| req_wide | input | 1 | Data access uses the 16-bit address |
| req_addr | input | 16 | Access address |
| req_wdata | input | 8 | Byte to write |
| slot_ack | output | 1 | High in the phase whose closing edge samples a request |
| p0_wr | input | 1 | Core write to the low port latch |
| p2_wr | input | 1 | Core write to the high port latch |
| port_wdata | input | 8 | Value for a core port write |
| p0_latch | output | 8 | Low port latch |
| p2_latch | output | 8 | High port latch |
| rsp_valid | output | 1 | Returned byte valid for one clock |
| rsp_data | output | 8 | Fetched or read byte |
| ale | output | 1 | Address latch enable |
| psen_n | output | 1 | Code read strobe, active low |
| rd_n | output | 1 | Data read strobe, active low |
| wr_n | output | 1 | Data write strobe, active low |
| p0_out | output | 8 | Low address / write data |
| p0_oe | output | 1 | Drive enable for the low port |
| p0_in | input | 8 | Byte returned by the bus |
| p2_out | output | 8 | High address or high port latch |

## Verification
Every pin and latch is registered. A value for phase k is therefore visible for the whole clock that follows the k-th edge after the sampling edge, and the bench compares it at the falling edge in the middle of that clock. The bench counts phases in its own model from the sampling edge. A returned byte is due one clock after its capture edge: phase 6 for a fetch and phase 11 for a read. Latch updates are due in phase 0, right after the sampling edge. The ALE count is checked over each complete 12-clock window.

// File: rtl/xbus_pkg.sv
package xbus_pkg;
    localparam int ADDR_W = 16;
    localparam int DATA_W = 8;

    typedef enum logic [1:0] {
        ACC_NONE  = 2'd0,
        ACC_FETCH = 2'd1,
        ACC_READ  = 2'd2,
        ACC_WRITE = 2'd3
    } acc_kind_e;

    typedef struct packed {
        acc_kind_e           kind;
        logic                wide;
        logic [ADDR_W-1:0]   addr;
        logic [DATA_W-1:0]   wdata;
    } acc_cmd_t;
endpackage

// File: rtl/xbus_timer.sv
module xbus_timer #(
    parameter int CYC = 12,
    parameter int PW  = 4
) (
    input  logic          clk,
    input  logic          rst_n,
    output logic [PW-1:0] ph_q,
    output logic [PW-1:0] ph_d,
    output logic          wrap
);
    localparam logic [PW-1:0] PH_LAST = PW'(CYC - 1);

    always_comb begin
        wrap = (ph_q == PH_LAST);
        ph_d = wrap ? '0 : ph_q + PW'(1);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) ph_q <= PH_LAST;
        else        ph_q <= ph_d;
    end

    AST_PHASE_WRAP: assert property (@(posedge clk) disable iff (!rst_n)
        (ph_q == PH_LAST) |=> (ph_q == '0)); // R1
endmodule

// File: rtl/xbus_wave.sv
module xbus_wave
    import xbus_pkg::*;
#(
    parameter int CYC = 12,
    parameter int PW  = 4
) (
    input  logic [PW-1:0]     ph,
    input  acc_cmd_t          cmd,
    input  logic [DATA_W-1:0] p2_latch,
    output logic              ale,
    output logic              psen_n,
    output logic              rd_n,
    output logic              wr_n,
    output logic              p0_oe,
    output logic [DATA_W-1:0] p0_out,
    output logic [DATA_W-1:0] p2_out
);
    localparam int HALF = CYC / 2;
    localparam logic [PW-1:0] ADR_END = PW'(1);
    localparam logic [PW-1:0] AL2_BEG = PW'(HALF);
    localparam logic [PW-1:0] AL2_END = PW'(HALF + 1);
    localparam logic [PW-1:0] PS_BEG  = PW'(3);
    localparam logic [PW-1:0] PS_END  = PW'(HALF - 1);
    localparam logic [PW-1:0] ST_BEG  = PW'(5);
    localparam logic [PW-1:0] ST_END  = PW'(CYC - 2);

    logic is_data;
    logic is_ext;
    logic addr_ph;

    always_comb begin
        is_data = (cmd.kind == ACC_READ) || (cmd.kind == ACC_WRITE);
        is_ext  = (cmd.kind != ACC_NONE);
        addr_ph = (ph <= ADR_END);

        ale    = addr_ph || (!is_data && (ph >= AL2_BEG) && (ph <= AL2_END));
        psen_n = !((cmd.kind == ACC_FETCH) && (ph >= PS_BEG) && (ph <= PS_END));
        rd_n   = !((cmd.kind == ACC_READ)  && (ph >= ST_BEG) && (ph <= ST_END));
        wr_n   = !((cmd.kind == ACC_WRITE) && (ph >= ST_BEG) && (ph <= ST_END));

        p0_oe  = (is_ext && addr_ph) || (cmd.kind == ACC_WRITE);
        if (addr_ph)                     p0_out = cmd.addr[DATA_W-1:0];
        else if (cmd.kind == ACC_WRITE)  p0_out = cmd.wdata;
        else                             p0_out = '1;

        if ((cmd.kind == ACC_FETCH) || (is_data && cmd.wide))
            p2_out = cmd.addr[ADDR_W-1:DATA_W];
        else
            p2_out = p2_latch;
    end
endmodule

// File: rtl/xbus_ports.sv
module xbus_ports
    import xbus_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              take,
    input  acc_kind_e         kind,
    input  logic              p0_wr,
    input  logic              p2_wr,
    input  logic [DATA_W-1:0] wdata,
    output logic [DATA_W-1:0] p0_q,
    output logic [DATA_W-1:0] p2_q,
    output logic [DATA_W-1:0] p2_d
);
    typedef struct packed {
        logic [DATA_W-1:0] p0;
        logic [DATA_W-1:0] p2;
    } lat_t;

    lat_t l_d, l_q;
    logic ext_take;
    logic fetch_take;

    always_comb begin
        ext_take   = take && (kind != ACC_NONE);
        fetch_take = take && (kind == ACC_FETCH);
        l_d = l_q;
        if (ext_take)   l_d.p0 = '1;
        else if (p0_wr) l_d.p0 = wdata;
        if (fetch_take) l_d.p2 = '1;
        else if (p2_wr) l_d.p2 = wdata;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) l_q <= '1;
        else        l_q <= l_d;
    end

    assign p0_q = l_q.p0;
    assign p2_q = l_q.p2;
    assign p2_d = l_d.p2;

    AST_P0_CLEARED: assert property (@(posedge clk) disable iff (!rst_n)
        ext_take |=> (l_q.p0 == '1)); // R8
    AST_P2_KEPT: assert property (@(posedge clk) disable iff (!rst_n)
        (take && ((kind == ACC_READ) || (kind == ACC_WRITE)) && !p2_wr) |=> $stable(l_q.p2)); // R8
endmodule

// File: rtl/xbus_seq.sv
module xbus_seq
    import xbus_pkg::*;
#(
    parameter int STATES    = 6,
    parameter int PH_PER_ST = 2
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        req_valid,
    input  logic [1:0]  req_kind,
    input  logic        req_wide,
    input  logic [15:0] req_addr,
    input  logic [7:0]  req_wdata,
    output logic        slot_ack,
    input  logic        p0_wr,
    input  logic        p2_wr,
    input  logic [7:0]  port_wdata,
    output logic [7:0]  p0_latch,
    output logic [7:0]  p2_latch,
    output logic        rsp_valid,
    output logic [7:0]  rsp_data,
    output logic        ale,
    output logic        psen_n,
    output logic        rd_n,
    output logic        wr_n,
    output logic [7:0]  p0_out,
    output logic        p0_oe,
    input  logic [7:0]  p0_in,
    output logic [7:0]  p2_out
);
    localparam int CYC = STATES * PH_PER_ST;
    localparam int PW  = $clog2(CYC);
    localparam logic [PW-1:0] PH_LAST = PW'(CYC - 1);
    localparam logic [PW-1:0] PS_END  = PW'(CYC / 2 - 1);
    localparam logic [PW-1:0] ST_BEG  = PW'(5);
    localparam logic [PW-1:0] ST_END  = PW'(CYC - 2);

    typedef struct packed {
        acc_cmd_t          cmd;
        logic              ale;
        logic              psen_n;
        logic              rd_n;
        logic              wr_n;
        logic              p0_oe;
        logic [DATA_W-1:0] p0_out;
        logic [DATA_W-1:0] p2_out;
        logic              slot;
        logic              rsp_valid;
        logic [DATA_W-1:0] rsp_data;
    } seq_t;

    localparam seq_t SEQ_RST = '{
        cmd: '0, ale: 1'b0, psen_n: 1'b1, rd_n: 1'b1, wr_n: 1'b1,
        p0_oe: 1'b0, p0_out: '1, p2_out: '1, slot: 1'b1,
        rsp_valid: 1'b0, rsp_data: '0
    };

    seq_t s_d, s_q;

    logic [PW-1:0]     ph_q, ph_d;
    logic              wrap;
    acc_cmd_t          cmd_next;
    logic [DATA_W-1:0] p2_next;
    logic              w_ale, w_psen_n, w_rd_n, w_wr_n, w_p0_oe;
    logic [DATA_W-1:0] w_p0_out, w_p2_out;

    xbus_timer #(.CYC(CYC), .PW(PW)) u_timer (
        .clk   (clk),
        .rst_n (rst_n),
        .ph_q  (ph_q),
        .ph_d  (ph_d),
        .wrap  (wrap)
    );

    always_comb begin
        cmd_next = s_q.cmd;
        if (wrap) begin
            if (req_valid) begin
                cmd_next.kind  = acc_kind_e'(req_kind);
                cmd_next.wide  = req_wide;
                cmd_next.addr  = req_addr;
                cmd_next.wdata = req_wdata;
            end else begin
                cmd_next = '0;
            end
        end
    end

    xbus_ports u_ports (
        .clk   (clk),
        .rst_n (rst_n),
        .take  (wrap),
        .kind  (cmd_next.kind),
        .p0_wr (p0_wr),
        .p2_wr (p2_wr),
        .wdata (port_wdata),
        .p0_q  (p0_latch),
        .p2_q  (p2_latch),
        .p2_d  (p2_next)
    );

    xbus_wave #(.CYC(CYC), .PW(PW)) u_wave (
        .ph       (ph_d),
        .cmd      (cmd_next),
        .p2_latch (p2_next),
        .ale      (w_ale),
        .psen_n   (w_psen_n),
        .rd_n     (w_rd_n),
        .wr_n     (w_wr_n),
        .p0_oe    (w_p0_oe),
        .p0_out   (w_p0_out),
        .p2_out   (w_p2_out)
    );

    always_comb begin
        s_d        = s_q;
        s_d.cmd    = cmd_next;
        s_d.ale    = w_ale;
        s_d.psen_n = w_psen_n;
        s_d.rd_n   = w_rd_n;
        s_d.wr_n   = w_wr_n;
        s_d.p0_oe  = w_p0_oe;
        s_d.p0_out = w_p0_out;
        s_d.p2_out = w_p2_out;
        s_d.slot   = (ph_d == PH_LAST);
        s_d.rsp_valid = ((s_q.cmd.kind == ACC_FETCH) && (ph_q == PS_END)) ||
                        ((s_q.cmd.kind == ACC_READ)  && (ph_q == ST_END));
        if (s_d.rsp_valid) s_d.rsp_data = p0_in;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) s_q <= SEQ_RST;
        else        s_q <= s_d;
    end

    assign slot_ack  = s_q.slot;
    assign rsp_valid = s_q.rsp_valid;
    assign rsp_data  = s_q.rsp_data;
    assign ale       = s_q.ale;
    assign psen_n    = s_q.psen_n;
    assign rd_n      = s_q.rd_n;
    assign wr_n      = s_q.wr_n;
    assign p0_out    = s_q.p0_out;
    assign p0_oe     = s_q.p0_oe;
    assign p2_out    = s_q.p2_out;

    AST_STROBE_ONEHOT: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({~s_q.psen_n, ~s_q.rd_n, ~s_q.wr_n})); // R9
    AST_ALE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        s_q.ale |-> (s_q.psen_n && s_q.rd_n && s_q.wr_n)); // R9
    AST_RD_START: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(s_q.rd_n) |-> (ph_q == ST_BEG)); // R5
    AST_WR_START: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(s_q.wr_n) |-> (ph_q == ST_BEG)); // R6
    AST_RSP_KIND: assert property (@(posedge clk) disable iff (!rst_n)
        s_q.rsp_valid |-> ((s_q.cmd.kind == ACC_FETCH) || (s_q.cmd.kind == ACC_READ))); // R4
endmodule

// File: tb/tb_xbus_seq.sv
module tb_xbus_seq;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_valid = 1'b0;
    logic [1:0]  req_kind = 2'd0;
    logic        req_wide = 1'b0;
    logic [15:0] req_addr = '0;
    logic [7:0]  req_wdata = '0;
    logic        p0_wr = 1'b0;
    logic        p2_wr = 1'b0;
    logic [7:0]  port_wdata = '0;
    logic        slot_ack, rsp_valid, ale, psen_n, rd_n, wr_n, p0_oe;
    logic [7:0]  p0_latch, p2_latch, rsp_data, p0_out, p2_out, p0_in;

    int errs = 0;
    int checks = 0;
    int cyc = 0;
    bit finished = 0;

    always #4 clk = ~clk;

    xbus_seq dut (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_kind(req_kind),
        .req_wide(req_wide), .req_addr(req_addr), .req_wdata(req_wdata),
        .slot_ack(slot_ack), .p0_wr(p0_wr), .p2_wr(p2_wr), .port_wdata(port_wdata),
        .p0_latch(p0_latch), .p2_latch(p2_latch), .rsp_valid(rsp_valid),
        .rsp_data(rsp_data), .ale(ale), .psen_n(psen_n), .rd_n(rd_n), .wr_n(wr_n),
        .p0_out(p0_out), .p0_oe(p0_oe), .p0_in(p0_in), .p2_out(p2_out)
    );

    // ---------------- behavioural external memory ----------------
    logic [7:0] lat_lo = '0;
    logic [7:0] dmem [256];
    logic [7:0] emem [256];

    function automatic logic [7:0] code_of(input logic [15:0] a);
        return a[7:0] ^ {a[11:8], a[15:12]} ^ 8'hA5;
    endfunction

    function automatic logic [7:0] idx(input logic [7:0] hi, input logic [7:0] lo);
        return hi ^ lo;
    endfunction

    always @(negedge clk) begin
        if (ale) lat_lo <= p0_out;
        if (!wr_n) dmem[idx(p2_out, lat_lo)] <= p0_out;
    end

    assign p0_in = !psen_n ? code_of({p2_out, lat_lo}) :
                   (!rd_n ? dmem[idx(p2_out, lat_lo)] : 8'hFF);

    // ---------------- reference model ----------------
    int         mph = 11;
    int         mk = 0;
    bit         mwide = 0;
    logic [15:0] maddr = '0;
    logic [7:0] mwd = '0;
    logic [7:0] ml0 = 8'hFF, ml2 = 8'hFF;
    bit         mrv = 0;
    logic [7:0] mrd = '0;

    always @(posedge clk) begin
        if (!rst_n) begin
            mph = 11; mk = 0; ml0 = 8'hFF; ml2 = 8'hFF; mrv = 0;
        end else begin
            mrv = 0;
            if (mk == 1 && mph == 5) begin mrv = 1; mrd = code_of(maddr); end
            if (mk == 2 && mph == 10) begin
                mrv = 1;
                mrd = emem[idx(mwide ? maddr[15:8] : ml2, maddr[7:0])];
            end
            if (mph == 11) begin
                mk = req_valid ? int'(req_kind) : 0;
                mwide = req_wide; maddr = req_valid ? req_addr : 16'h0; mwd = req_wdata;
                if (mk != 0) ml0 = 8'hFF; else if (p0_wr) ml0 = port_wdata;
                if (mk == 1) ml2 = 8'hFF; else if (p2_wr) ml2 = port_wdata;
                if (mk == 3) emem[idx(mwide ? maddr[15:8] : ml2, maddr[7:0])] = mwd;
                mph = 0;
            end else begin
                if (p0_wr) ml0 = port_wdata;
                if (p2_wr) ml2 = port_wdata;
                mph = mph + 1;
            end
        end
    end

    task automatic chk(input string tag, input logic [7:0] act, input logic [7:0] exp);
        checks++;
        if (act !== exp) begin
            errs++;
            $display("FAIL %s: got %0h expected %0h (phase %0d kind %0d)", tag, act, exp, mph, mk);
        end
    endtask

    // ---------------- per-clock comparison ----------------
    int  ale_cnt = 0;
    bit  ale_prev = 0;
    bit  seen_start = 0;

    always @(negedge clk) begin
        if (rst_n && !finished) begin
            bit e_ale, e_ps, e_rd, e_wr, e_oe;
            logic [7:0] e_p0, e_p2;
            e_ale = (mph <= 1) || (!(mk == 2 || mk == 3) && (mph == 6 || mph == 7));
            e_ps  = !(mk == 1 && mph >= 3 && mph <= 5);
            e_rd  = !(mk == 2 && mph >= 5 && mph <= 10);
            e_wr  = !(mk == 3 && mph >= 5 && mph <= 10);
            e_oe  = (mk != 0 && mph <= 1) || mk == 3;
            e_p0  = (mph <= 1) ? maddr[7:0] : mwd;
            e_p2  = (mk == 1 || (mk >= 2 && mwide)) ? maddr[15:8] : ml2;
            chk("R1 slot_ack", {7'd0, slot_ack}, {7'd0, mph == 11});
            chk("R2 ale", {7'd0, ale}, {7'd0, e_ale});
            chk("R3 p0_oe", {7'd0, p0_oe}, {7'd0, e_oe});
            if (e_oe) chk("R3/R6 p0_out", p0_out, e_p0);
            chk("R4 psen_n", {7'd0, psen_n}, {7'd0, e_ps});
            chk("R5 rd_n", {7'd0, rd_n}, {7'd0, e_rd});
            chk("R6 wr_n", {7'd0, wr_n}, {7'd0, e_wr});
            chk("R7 p2_out", p2_out, e_p2);
            chk("R8 p0_latch", p0_latch, ml0);
            chk("R8 p2_latch", p2_latch, ml2);
            chk("R4/R5 rsp_valid", {7'd0, rsp_valid}, {7'd0, mrv});
            if (mrv) chk("R4/R5 rsp_data", rsp_data, mrd);
            chk("R9 strobe overlap", {7'd0, (!psen_n + !rd_n + !wr_n > 1) || (ale && !(psen_n && rd_n && wr_n))}, 8'd0);
            if (ale && !ale_prev) ale_cnt++;
            ale_prev = ale;
            if (mph == 0 && !seen_start) begin seen_start = 1; ale_cnt = 1; end
            if (mph == 11 && seen_start) begin
                chk("R2 ale pulses per cycle", 8'(ale_cnt), (mk == 2 || mk == 3) ? 8'd1 : 8'd2);
                ale_cnt = 0;
            end
        end
    end

    // ---------------- stimulus ----------------
    task automatic mc(input int k, input bit w, input logic [15:0] a, input logic [7:0] d);
        @(negedge clk);
        while (!slot_ack) @(negedge clk);
        req_valid = 1'b1; req_kind = k[1:0]; req_wide = w; req_addr = a; req_wdata = d;
        @(negedge clk);
        req_valid = 1'b0; req_kind = 2'd0; req_wide = 1'b0; req_addr = '0; req_wdata = '0;
    endtask

    task automatic pw(input bit sel2, input logic [7:0] v);
        @(negedge clk);
        if (sel2) p2_wr = 1'b1; else p0_wr = 1'b1;
        port_wdata = v;
        @(negedge clk);
        p0_wr = 1'b0; p2_wr = 1'b0;
    endtask

    task automatic finish_run();
        if (!finished) begin
            finished = 1;
            $display("Result: errors=%0d of %0d checks", errs, checks);
            $finish;
        end
    endtask

    always @(posedge clk) begin
        cyc++;
        if (cyc > 20000 && !finished) begin
            errs++; checks++;
            $display("FAIL watchdog: got %0d expected below 20000 cycles", cyc);
            finish_run();
        end
    end

    initial begin
        for (int i = 0; i < 256; i++) begin
            dmem[i] = 8'(i * 3);
            emem[i] = 8'(i * 3);
        end
        repeat (3) @(negedge clk);
        // R1: reset state
        chk("R1 reset ale", {7'd0, ale}, 8'd0);
        chk("R1 reset strobes", {5'd0, psen_n, rd_n, wr_n}, 8'd7);
        chk("R1 reset p0_oe", {7'd0, p0_oe}, 8'd0);
        chk("R1 reset slot_ack", {7'd0, slot_ack}, 8'd1);
        chk("R1 reset p0_latch", p0_latch, 8'hFF);
        chk("R1 reset p2_latch", p2_latch, 8'hFF);
        rst_n = 1'b1;

        mc(0, 0, 16'h0, 8'h0);          // internal cycles, R2 R3
        mc(0, 0, 16'h0, 8'h0);
        mc(1, 0, 16'h1234, 8'h0);       // fetches, R4 R7
        mc(1, 1, 16'hABCD, 8'h0);
        pw(1, 8'h3C);                   // R8 core write of high latch
        mc(0, 0, 16'h0, 8'h0);          // R7 latch on p2_out
        mc(3, 0, 16'h0055, 8'h77);      // narrow write R6 R7
        mc(2, 0, 16'h0055, 8'h0);       // narrow read R5
        mc(3, 1, 16'h8811, 8'hC3);      // wide write
        mc(2, 1, 16'h8811, 8'h0);       // wide read, p2 kept R8
        mc(0, 0, 16'h0, 8'h0);
        pw(0, 8'h12);                   // R8 core write of low latch
        mc(0, 0, 16'h0, 8'h0);
        mc(2, 0, 16'h0042, 8'h0);       // external access clears p0 latch R8
        // R8 precedence: port writes on the taking edge of a fetch
        @(negedge clk);
        while (!slot_ack) @(negedge clk);
        req_valid = 1'b1; req_kind = 2'd1; req_addr = 16'h5A5A;
        p0_wr = 1'b1; p2_wr = 1'b1; port_wdata = 8'h44;
        @(negedge clk);
        req_valid = 1'b0; req_kind = 2'd0; req_addr = '0; p0_wr = 1'b0; p2_wr = 1'b0;
        // R8: port write on an internal taking edge applies
        @(negedge clk);
        while (!slot_ack) @(negedge clk);
        p2_wr = 1'b1; port_wdata = 8'h99;
        @(negedge clk);
        p2_wr = 1'b0;
        for (int i = 0; i < 8; i++) begin
            mc(1 + (i % 3), i[0], 16'(16'h0F31 * (i + 1)), 8'(8'h1D * i + 3));
        end
        mc(0, 0, 16'h0, 8'h0);
        repeat (14) @(negedge clk);
        finish_run();
    end
endmodule